// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns signal transitions on nineteen lines into interrupt requests and event pulses. Sixteen of the lines are fed from general-purpose pins. Each of these lines picks one of seven pin ports through a 4-bit port code, and always uses the pin whose index equals the line number. The remaining three lines take internal event signals that already run on the block's clock. Pin inputs first pass through a two-flop synchroniser. Each line then compares its current level with the level it held one cycle earlier, and reacts only to the edge directions that software has enabled for that line.

A detected edge, or a software trigger, latches a per-line pending flag. Software clears the flag by writing one to it. The interrupt request output for a line is the pending flag gated by that line's interrupt mask. A separate event mask lets the same detection produce a pulse that lasts one cycle. This pulse does not depend on the pending flag.

Software reaches every control register through a simple word-addressed write/read port. Reads are combinational. Writes take effect at the clock edge at which `bus_wr` is high.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Word addresses are: 0x0 interrupt mask, 0x1 event mask, 0x2 rising select, 0x3 falling select, 0x4 software trigger, 0x5 pending, and 0x8 to 0xB port-select words 0 to 3. Other addresses read as zero. In the per-line registers, bits 31:19 read as zero and writes to them are ignored. In the port-select words, bits 31:16 read as zero.
- R2: A 0-to-1 transition on a line whose rising-select bit is 1 sets that line's pending bit.
- R3: A 1-to-0 transition on a line whose falling-select bit is 1 sets the pending bit. With both select bits set, either direction sets it.
- R4: A level held steady, high or low, never sets a pending bit. A transition whose direction is not selected never sets one either.
- R5: Writing 1 to a bit at address 0x5 clears that pending bit. Writing 0 leaves it unchanged.
- R6: `irq_req[n]` is 1 exactly while pending bit n and interrupt-mask bit n are both 1.
- R7: When an edge or a software trigger is detected on line n and event-mask bit n is 1, `evt_pulse[n]` is high for exactly the following cycle. This does not depend on the pending bit.
- R8: Writing 1 to bit n at address 0x4 sets software-trigger bit n and sets pending bit n at the same clock edge. Clearing pending bit n through address 0x5 also clears software-trigger bit n.
- R9: Line n (0 to 15) reads pin n of port k, where k is the 4-bit code at bits (n mod 4)*4+3 to (n mod 4)*4 of port-select word n/4. Pin n of port k is `gpio_in[k*16+n]`. Codes 0 to 6 select ports 0 to 6. Codes 7 to 15 hold the line at constant 0.
- R10: A pin change applied before clock edge k sets the pending bit at edge k+2. A change on `int_evt[j]` (line 16+j) applied before edge k sets the pending bit at edge k.
- R11: If an edge is detected in the same cycle as a write-one-to-clear of that pending bit, the pending bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpio_in | input | 112 | Raw pins, port k pin n at bit k*16+n |
| int_evt | input | 3 | Internal event inputs for lines 16 to 18, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_req | output | 19 | Per-line interrupt request |
| evt_pulse | output | 19 | Per-line one-cycle event pulse |

## Verification
The hardest case to reach is a new edge arriving in the very cycle in which software writes one to clear the same pending bit. The clear has to land at that exact edge, and for pin lines the timing is hidden behind the synchroniser. The stimulus reaches it on an internal event line, which has no synchroniser delay. The bench first sets and then drops that line's level. It then raises the level again at the same negative edge at which it drives the clearing write. The pin path's latency is checked separately, cycle by cycle, with reads of the pending register. The unmapped port codes are checked by toggling the same pin on every port while the line's code is 9.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_IMASK = 4'h0;
  localparam logic [ADDR_W-1:0] A_EMASK = 4'h1;
  localparam logic [ADDR_W-1:0] A_RISE  = 4'h2;
  localparam logic [ADDR_W-1:0] A_FALL  = 4'h3;
  localparam logic [ADDR_W-1:0] A_SWTRG = 4'h4;
  localparam logic [ADDR_W-1:0] A_PEND  = 4'h5;
  localparam logic [ADDR_W-1:0] A_PSEL0 = 4'h8;

  // which port-select word holds a line's field
  function automatic int psel_word(input int line, input int per_reg);
    return line / per_reg;
  endfunction

  // bit offset of a line's field inside its word
  function automatic int psel_off(input int line, input int per_reg, input int sel_w);
    return (line % per_reg) * sel_w;
  endfunction

  // enabled-edge test for one line
  function automatic logic edge_fire(input logic cur, input logic prv,
                                     input logic rs, input logic fs);
    return (cur & ~prv & rs) | (~cur & prv & fs);
  endfunction
endpackage

// File: rtl/eic_pin_mux.sv
module eic_pin_mux #(
  parameter int NUM_PORTS = 7,
  parameter int PINS      = 16,
  parameter int SEL_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PORTS*PINS-1:0] pins_raw,
  input  logic [PINS*SEL_W-1:0]     sel_flat,
  output logic [PINS-1:0]           lvl
);
  localparam int RAW_W = NUM_PORTS * PINS;

  logic [RAW_W-1:0] sync1_q, sync2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pins_raw;
      sync2_q <= sync1_q;
    end
  end

  for (genvar n = 0; n < PINS; n++) begin : g_line
    logic [SEL_W-1:0] code;
    logic             pick;
    assign code = sel_flat[n*SEL_W +: SEL_W];
    always_comb begin
      pick = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (int'(code) == p) pick = sync2_q[p*PINS + n];
      end
    end
    assign lvl[n] = pick;
  end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int LINES   = 19,
  parameter int PINS    = 16,
  parameter int SEL_W   = 4,
  parameter int PER_REG = 4,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [LINES-1:0]      pend,
  input  logic [LINES-1:0]      swbits,
  output logic [LINES-1:0]      imask,
  output logic [LINES-1:0]      emask,
  output logic [LINES-1:0]      rise,
  output logic [LINES-1:0]      fall,
  output logic [LINES-1:0]      sw_set,
  output logic [LINES-1:0]      pend_clr,
  output logic [PINS*SEL_W-1:0] sel_flat
);
  localparam int NUM_SEL = PINS / PER_REG;
  localparam int SREG_W  = PER_REG * SEL_W;

  logic [SREG_W-1:0] psel_q [NUM_SEL];
  logic [LINES-1:0]  wr_lines;
  logic              unused_wd;

  assign wr_lines  = bus_wdata[LINES-1:0];
  assign unused_wd = ^bus_wdata[DATA_W-1:LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imask <= '0;
      emask <= '0;
      rise  <= '0;
      fall  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_IMASK) imask <= wr_lines;
      if (bus_addr == A_EMASK) emask <= wr_lines;
      if (bus_addr == A_RISE)  rise  <= wr_lines;
      if (bus_addr == A_FALL)  fall  <= wr_lines;
    end
  end

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_psel
    localparam logic [ADDR_W-1:0] MY_ADDR = A_PSEL0 + ADDR_W'(k);
    always_ff @(posedge clk) begin
      if (!rst_n)                            psel_q[k] <= '0;
      else if (bus_wr && bus_addr == MY_ADDR) psel_q[k] <= bus_wdata[SREG_W-1:0];
    end
  end

  for (genvar n = 0; n < PINS; n++) begin : g_field
    localparam int WI = psel_word(n, PER_REG);
    localparam int OF = psel_off(n, PER_REG, SEL_W);
    assign sel_flat[n*SEL_W +: SEL_W] = psel_q[WI][OF +: SEL_W];
  end

  assign sw_set   = (bus_wr && bus_addr == A_SWTRG) ? wr_lines : '0;
  assign pend_clr = (bus_wr && bus_addr == A_PEND)  ? wr_lines : '0;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_IMASK: bus_rdata[LINES-1:0] = imask;
      A_EMASK: bus_rdata[LINES-1:0] = emask;
      A_RISE:  bus_rdata[LINES-1:0] = rise;
      A_FALL:  bus_rdata[LINES-1:0] = fall;
      A_SWTRG: bus_rdata[LINES-1:0] = swbits;
      A_PEND:  bus_rdata[LINES-1:0] = pend;
      default: begin
        for (int k = 0; k < NUM_SEL; k++) begin
          if (bus_addr == A_PSEL0 + ADDR_W'(k)) bus_rdata[SREG_W-1:0] = psel_q[k];
        end
      end
    endcase
  end
endmodule

// File: rtl/eic_edge_core.sv
module eic_edge_core
  import eic_pkg::*;
#(
  parameter int LINES = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl,
  input  logic [LINES-1:0] rise,
  input  logic [LINES-1:0] fall,
  input  logic [LINES-1:0] emask,
  input  logic [LINES-1:0] sw_set,
  input  logic [LINES-1:0] pend_clr,
  output logic [LINES-1:0] line_hit,
  output logic [LINES-1:0] pend,
  output logic [LINES-1:0] swbits,
  output logic [LINES-1:0] evt_pulse
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] edge_det;

  for (genvar n = 0; n < LINES; n++) begin : g_edge
    assign edge_det[n] = edge_fire(lvl[n], prev_q[n], rise[n], fall[n]);
  end

  assign line_hit = edge_det | sw_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      pend      <= '0;
      swbits    <= '0;
      evt_pulse <= '0;
    end else begin
      prev_q    <= lvl;
      pend      <= (pend & ~pend_clr) | line_hit;
      swbits    <= (swbits & ~pend_clr) | sw_set;
      evt_pulse <= line_hit & emask;
    end
  end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES   = 19,
  parameter int NUM_PORTS   = 7,
  parameter int PIN_LINES   = 16,
  parameter int SEL_W       = 4,
  parameter int SEL_PER_REG = 4,
  parameter int DATA_W      = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PORTS*PIN_LINES-1:0] gpio_in,
  input  logic [NUM_LINES-PIN_LINES-1:0] int_evt,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [NUM_LINES-1:0]           irq_req,
  output logic [NUM_LINES-1:0]           evt_pulse
);
  logic [PIN_LINES*SEL_W-1:0] sel_flat;
  logic [PIN_LINES-1:0]       pin_lvl;
  logic [NUM_LINES-1:0]       line_lvl;
  logic [NUM_LINES-1:0]       imask_v, emask_v, rise_v, fall_v;
  logic [NUM_LINES-1:0]       sw_set, pend_clr, line_hit, pend_vec, sw_vec;

  eic_pin_mux #(.NUM_PORTS(NUM_PORTS), .PINS(PIN_LINES), .SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .pins_raw(gpio_in), .sel_flat(sel_flat), .lvl(pin_lvl)
  );

  assign line_lvl = {int_evt, pin_lvl};

  eic_regs #(.LINES(NUM_LINES), .PINS(PIN_LINES), .SEL_W(SEL_W),
             .PER_REG(SEL_PER_REG), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend(pend_vec), .swbits(sw_vec),
    .imask(imask_v), .emask(emask_v), .rise(rise_v), .fall(fall_v),
    .sw_set(sw_set), .pend_clr(pend_clr), .sel_flat(sel_flat)
  );

  eic_edge_core #(.LINES(NUM_LINES)) u_core (
    .clk(clk), .rst_n(rst_n), .lvl(line_lvl), .rise(rise_v), .fall(fall_v),
    .emask(emask_v), .sw_set(sw_set), .pend_clr(pend_clr), .line_hit(line_hit),
    .pend(pend_vec), .swbits(sw_vec), .evt_pulse(evt_pulse)
  );

  assign irq_req = pend_vec & imask_v;
endmodule

// File: rtl/eic_chk.sv
module eic_chk
  import eic_pkg::*;
#(
  parameter int LINES  = 19,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [LINES-1:0]  line_hit,
  input logic [LINES-1:0]  pend,
  input logic [LINES-1:0]  emask,
  input logic [LINES-1:0]  rise,
  input logic [LINES-1:0]  fall,
  input logic [LINES-1:0]  sw_set,
  input logic [LINES-1:0]  evt_pulse
);
  // R1
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:LINES] == '0);

  // R4
  hit_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_hit & ~(rise | fall | sw_set)) == '0);

  // R4
  no_spurious_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend & ~$past(pend) & ~$past(line_hit)) == '0));

  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PEND) |=>
      ((pend & $past(bus_wdata[LINES-1:0]) & ~$past(line_hit)) == '0));

  // R11
  hit_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_hit) |=> ((pend & $past(line_hit)) == $past(line_hit)));

  // R7
  evt_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (evt_pulse == ($past(line_hit) & $past(emask))));
endmodule

bind edge_irq_ctrl eic_chk #(.LINES(NUM_LINES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_hit(line_hit),
  .pend(pend_vec), .emask(emask_v), .rise(rise_v), .fall(fall_v),
  .sw_set(sw_set), .evt_pulse(evt_pulse)
);

// File: tb/edge_irq_ctrl_bench.sv
module edge_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [111:0] gpio_in = '0;
  logic [2:0]  int_evt = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [18:0] irq_req, evt_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_ctrl u_edge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .int_evt(int_evt),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .evt_pulse(evt_pulse)
  );

  // reference model state
  logic [18:0]  m_im, m_em, m_rs, m_fs, m_sw, m_pd, m_ev, m_prev;
  logic [31:0]  m_ps [4];
  logic [111:0] m_s1, m_s2;
  logic [18:0]  t_lv, t_hit, t_swf, t_clr;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_im = '0; m_em = '0; m_rs = '0; m_fs = '0; m_sw = '0; m_pd = '0;
      m_ev = '0; m_prev = '0; m_s1 = '0; m_s2 = '0;
      for (int k = 0; k < 4; k++) m_ps[k] = '0;
    end else begin
      for (int i = 0; i < 16; i++) begin
        int code;
        code = int'((m_ps[i/4] >> ((i%4)*4)) & 32'hF);
        t_lv[i] = (code < 7) ? m_s2[code*16 + i] : 1'b0;
      end
      t_lv[18:16] = int_evt;
      t_swf = (bus_wr && bus_addr == 4'h4) ? bus_wdata[18:0] : '0;
      t_clr = (bus_wr && bus_addr == 4'h5) ? bus_wdata[18:0] : '0;
      for (int i = 0; i < 19; i++)
        t_hit[i] = t_swf[i] || (t_lv[i] && !m_prev[i] && m_rs[i]) ||
                   (!t_lv[i] && m_prev[i] && m_fs[i]);
      m_pd = (m_pd & ~t_clr) | t_hit;
      m_sw = (m_sw & ~t_clr) | t_swf;
      m_ev = t_hit & m_em;
      if (bus_wr) begin
        case (bus_addr)
          4'h0: m_im = bus_wdata[18:0];
          4'h1: m_em = bus_wdata[18:0];
          4'h2: m_rs = bus_wdata[18:0];
          4'h3: m_fs = bus_wdata[18:0];
          4'h8, 4'h9, 4'hA, 4'hB: m_ps[bus_addr - 4'h8] = bus_wdata & 32'hFFFF;
          default: ;
        endcase
      end
      m_prev = t_lv;
      m_s2 = m_s1;
      m_s1 = gpio_in;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a)
      4'h0: return {13'b0, m_im};
      4'h1: return {13'b0, m_em};
      4'h2: return {13'b0, m_rs};
      4'h3: return {13'b0, m_fs};
      4'h4: return {13'b0, m_sw};
      4'h5: return {13'b0, m_pd};
      4'h8, 4'h9, 4'hA, 4'hB: return m_ps[a - 4'h8];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      chk("R6 irq_req vs model", {13'b0, irq_req}, {13'b0, m_pd & m_im});
      chk("R7 evt_pulse vs model", {13'b0, evt_pulse}, {13'b0, m_ev});
      chk("R1 bus_rdata vs model", bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  logic [31:0] r;
  logic [18:0] rs_cfg;

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("reset irq_req", {13'b0, irq_req}, 32'h0);
    chk("reset evt_pulse", {13'b0, evt_pulse}, 32'h0);
    chk("reset pending", bus_rdata, 32'h0);
    rst_n = 1'b1;

    // line 3 from port code 2, rising edges, interrupt enabled
    wr(4'h8, 32'h0000_2000);
    rs_cfg = 19'h8;
    wr(4'h2, {13'b0, rs_cfg});
    wr(4'h0, 32'h8);
    rd(4'h5, r);
    gpio_in[2*16+3] = 1'b1;
    #2; chk("R10 before edge k", bus_rdata & 32'h8, 32'h0);
    @(negedge clk); #2; chk("R10 after edge k", bus_rdata & 32'h8, 32'h0);
    @(negedge clk); #2; chk("R10 after edge k+1", bus_rdata & 32'h8, 32'h0);
    @(negedge clk); #2; chk("R2 R10 pending after edge k+2", bus_rdata & 32'h8, 32'h8);
    chk("R6 irq raised", {13'b0, irq_req} & 32'h8, 32'h8);

    // write zero has no effect, write one clears, steady high stays quiet
    wr(4'h5, 32'h0);
    rd(4'h5, r); chk("R5 write zero keeps pending", r & 32'h8, 32'h8);
    wr(4'h5, 32'h8);
    rd(4'h5, r); chk("R5 write one clears", r & 32'h8, 32'h0);
    chk("R6 irq dropped", {13'b0, irq_req} & 32'h8, 32'h0);
    idle(10);
    rd(4'h5, r); chk("R4 steady high no pending", r & 32'h8, 32'h0);
    @(negedge clk); gpio_in[2*16+3] = 1'b0;
    idle(5);
    rd(4'h5, r); chk("R4 unselected falling edge ignored", r & 32'h8, 32'h0);

    // both edges selected
    wr(4'h3, 32'h8);
    @(negedge clk); gpio_in[2*16+3] = 1'b1;
    idle(5);
    wr(4'h5, 32'h8);
    @(negedge clk); gpio_in[2*16+3] = 1'b0;
    idle(5);
    rd(4'h5, r); chk("R3 falling edge sets pending", r & 32'h8, 32'h8);
    wr(4'h5, 32'h8);
    @(negedge clk); gpio_in[2*16+3] = 1'b1;
    idle(5);
    rd(4'h5, r); chk("R3 rising edge with both selected", r & 32'h8, 32'h8);
    wr(4'h5, 32'h8);

    // line 5 with unmapped code 9, then port code 6
    wr(4'h9, 32'h0000_0090);
    rs_cfg = rs_cfg | 19'h20;
    wr(4'h2, {13'b0, rs_cfg});
    wr(4'h3, 32'h28);
    @(negedge clk);
    for (int p = 0; p < 7; p++) gpio_in[p*16+5] = 1'b1;
    idle(5);
    @(negedge clk);
    for (int p = 0; p < 7; p++) gpio_in[p*16+5] = 1'b0;
    idle(5);
    rd(4'h5, r); chk("R9 code 9 sees constant zero", r & 32'h20, 32'h0);
    wr(4'h9, 32'h0000_0060);
    @(negedge clk); gpio_in[6*16+5] = 1'b1;
    idle(5);
    rd(4'h5, r); chk("R9 code 6 selects last port", r & 32'h20, 32'h20);
    @(negedge clk); gpio_in[5*16+5] = 1'b1;
    wr(4'h5, 32'h20);
    idle(5);
    rd(4'h5, r); chk("R9 other port pin ignored", r & 32'h20, 32'h0);

    // internal line 17 event pulse, interrupt masked
    wr(4'h1, 32'h0002_0000);
    rs_cfg = rs_cfg | 19'h2_0000;
    wr(4'h2, {13'b0, rs_cfg});
    rd(4'h5, r);
    int_evt[1] = 1'b1;
    @(negedge clk); #2;
    chk("R7 R10 event pulse after one edge", {13'b0, evt_pulse} & 32'h2_0000, 32'h2_0000);
    chk("R6 masked line no irq", {13'b0, irq_req} & 32'h2_0000, 32'h0);
    @(negedge clk); #2;
    chk("R7 event pulse lasts one cycle", {13'b0, evt_pulse} & 32'h2_0000, 32'h0);
    chk("R10 internal pending", bus_rdata & 32'h2_0000, 32'h2_0000);

    // software trigger
    wr(4'h4, 32'h400);
    rd(4'h4, r); chk("R8 trigger bit reads one", r & 32'h400, 32'h400);
    rd(4'h5, r); chk("R8 trigger sets pending", r & 32'h400, 32'h400);
    wr(4'h5, 32'h400);
    rd(4'h4, r); chk("R8 clearing pending clears trigger", r & 32'h400, 32'h0);
    rd(4'h5, r); chk("R8 pending cleared", r & 32'h400, 32'h0);

    // reserved bits
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, r); chk("R1 upper mask bits zero", r, 32'h0007_FFFF);
    wr(4'hB, 32'hFFFF_FFFF);
    rd(4'hB, r); chk("R1 port-select upper bits zero", r, 32'h0000_FFFF);
    rd(4'h7, r); chk("R1 unused address reads zero", r, 32'h0);
    wr(4'h0, 32'h8);

    // set wins over clear in the same cycle
    rs_cfg = rs_cfg | 19'h1_0000;
    wr(4'h2, {13'b0, rs_cfg});
    @(negedge clk); int_evt[0] = 1'b1;
    idle(2);
    rd(4'h5, r); chk("R2 internal rising edge", r & 32'h1_0000, 32'h1_0000);
    @(negedge clk); int_evt[0] = 1'b0;
    idle(2);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'h5; bus_wdata = 32'h1_0000; int_evt[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(4'h5, r); chk("R11 set wins over clear", r & 32'h1_0000, 32'h1_0000);
    wr(4'h5, 32'h1_0000);
    rd(4'h5, r); chk("R5 later clear works", r & 32'h1_0000, 32'h0);

    idle(3);
    finish_run();
  end
endmodule